// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a 16 KB data cache placed between a core request port and a 64-bit memory bus. It takes 32-bit word loads and stores on 32-bit byte addresses. Its 512 lines of 32 bytes are arranged as 256 sets of two ways. Both ways of the indexed set are tag-checked at the same time. A hit answers from the array. A miss fetches the whole line through a separate fill buffer in four 64-bit beats. The word the core asked for is handed back as soon as its beat arrives, and the line is copied into the array only after the last beat. Stores that hit stay in the cache and mark the line dirty. A store that misses first brings the line in and then merges the word into it. A dirty victim is written back in full before the fill request goes out.

The core interface uses a ready/valid handshake and takes one request at a time. The core is held off (`req_ready` low) from the moment a request is accepted until the lookup or the line install has finished. The memory side has three channels:
- a read-request channel with its own handshake,
- a beat-return strobe that carries no back-pressure,
- a beat-write channel with its own handshake.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a request. On `req_valid` it moves to `ST_LOOKUP`.
- `ST_LOOKUP`: compares the tags. On a hit it returns to `ST_IDLE`. On a miss it goes to `ST_EVICT` if the chosen victim is valid and dirty, and to `ST_FETCH_REQ` otherwise.
- `ST_EVICT`: sends the four write beats. After the fourth accepted beat it moves to `ST_FETCH_REQ`.
- `ST_FETCH_REQ`: holds the read request. On `mem_rd_ready` it moves to `ST_FETCH_DATA`.
- `ST_FETCH_DATA`: collects the returned beats. After the fourth beat it moves to `ST_INSTALL`.
- `ST_INSTALL`: writes the line into the array, then returns to `ST_IDLE`.

Top module: `cache2w_ctrl`

## Requirements
- R1: After reset every line is invalid and clean, and the controller is idle: `req_ready`=1, and `resp_valid`, `mem_rd_valid` and `mem_wr_valid` are all 0. The first access to any address after reset is a miss.
- R2: The address is split as follows: bits 4..0 are the byte offset, bits 12..5 the set index and bits 31..13 the 19-bit tag. The returned word is word number addr[4:2] of the line, where word k occupies line bits 32k+31..32k. Request addresses are word aligned (bits 1..0 are zero).
- R3: A load hit returns the addressed word with `resp_valid` high for exactly one cycle, two clock edges after the edge that accepts the request. A hit causes no memory read and no memory write.
- R4: A miss issues one read request whose address is the line base plus the critical beat offset, addr[4:3]×8. Beats return in wrap order: critical, critical+1, … modulo 4. Beat b carries bytes 8b..8b+7, with the lower-addressed word in bits 31..0. The line enters the array only after all four beats have arrived, so every word of the line reads back correctly afterwards.
- R5: On a miss, `resp_valid` rises on the edge after the critical beat is received, while the other three beats are still outstanding. `req_ready` stays low until the line has been installed.
- R6: A store hit writes only the cache and sets the line dirty. It causes no memory traffic. Later loads return the stored value.
- R7: A store miss fetches the line, merges the store word into it and installs it dirty. The other words of that line keep their memory values.
- R8: The victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way not most recently accessed in that set. Each hit and each install records its way as the most recently accessed. At most one way hits.
- R9: A dirty victim is written back as four beats at line offsets 0, 8, 16 and 24, in that order, all before the read request. A clean victim is dropped without any write.
- R10: While `mem_rd_valid` or `mem_wr_valid` is waiting for its ready, the valid stays high and the address (and the write data) stays unchanged. Results are unaffected by back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Word-aligned byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Load result (unspecified for stores) |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Address of the critical beat |
| mem_rdata_valid | input | 1 | A returned beat is present |
| mem_rdata | input | 64 | Returned beat data |
| mem_wr_valid | output | 1 | Write-back beat present |
| mem_wr_ready | input | 1 | Memory accepts the write beat |
| mem_wr_addr | output | 32 | Byte address of the write beat |
| mem_wr_data | output | 64 | Write-back beat data |

## Verification
A hit responds two edges after the accepting edge. A miss responds one edge after the edge that captures the critical beat. Write-back beats move one per accepted handshake, and the install finishes one edge after the fourth returned beat. The bench drives and samples only on falling edges. It counts the falling edges from acceptance to `resp_valid`, expecting exactly two for hits. For misses it checks that exactly one beat has been captured when the response appears and that `req_ready` is still low at that point. The memory model logs every request and beat on the falling edge before the edge that completes the handshake, so traffic counts, beat order and the write-back-before-fill order are compared against the logs.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FETCH_REQ,
        ST_FETCH_DATA,
        ST_INSTALL
    } cc_state_e;

    localparam int NUM_WAYS = 2;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
    parameter int NUM_SETS = 256,
    parameter int TAG_W    = 19,
    parameter int LINE_W   = 256,
    parameter int WORD_W   = 32,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WSEL_W  = $clog2(LINE_W / WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_line_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_dirty,
    input  logic              wr_word_en,
    input  logic [WSEL_W-1:0] wr_word_sel,
    input  logic [WORD_W-1:0] wr_word
);
    logic [TAG_W-1:0]    tag_mem  [NUM_SETS];
    logic [LINE_W-1:0]   line_mem [NUM_SETS];
    logic [NUM_SETS-1:0] valid_q;
    logic [NUM_SETS-1:0] dirty_q;

    assign rd_tag   = tag_mem[idx];
    assign rd_line  = line_mem[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    // Status bits: the only state that needs a reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_line_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= wr_dirty;
        end else if (wr_word_en) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag and data storage: no reset, qualified by valid.
    always_ff @(posedge clk) begin
        if (wr_line_en) begin
            tag_mem[idx]  <= wr_tag;
            line_mem[idx] <= wr_line;
        end else if (wr_word_en) begin
            line_mem[idx][wr_word_sel*WORD_W +: WORD_W] <= wr_word;
        end
    end

    // R4: an installed line is valid afterwards.
    a_r4_install_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_line_en |=> valid_q[$past(idx)]);

    // R6: a word store only ever lands on a valid line.
    a_r6_store_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word_en |-> rd_valid);
endmodule

// File: rtl/cache2w_fillbuf.sv
module cache2w_fillbuf #(
    parameter int BUS_W   = 64,
    parameter int BEATS   = 4,
    parameter int WORD_W  = 32,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int WPB    = BUS_W / WORD_W,
    localparam int WPB_W  = (WPB > 1) ? $clog2(WPB) : 1
) (
    input  logic                   clk,
    input  logic                   beat_en,
    input  logic [BEAT_W-1:0]      beat_idx,
    input  logic [BUS_W-1:0]       beat_data,
    input  logic                   merge_en,
    input  logic [WPB_W-1:0]       merge_sel,
    input  logic [WORD_W-1:0]      merge_word,
    output logic [BEATS*BUS_W-1:0] line_out
);
    logic [BUS_W-1:0] slot_q [BEATS];
    logic [BUS_W-1:0] merged;

    // Overlay the pending store word onto its beat as the beat arrives.
    always_comb begin
        merged = beat_data;
        for (int i = 0; i < WPB; i++) begin
            if (merge_en && merge_sel == WPB_W'(i)) begin
                merged[i*WORD_W +: WORD_W] = merge_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (beat_en) begin
            slot_q[beat_idx] <= merged;
        end
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_slot
        assign line_out[b*BUS_W +: BUS_W] = slot_q[b];
    end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int BUS_W      = 64,
    parameter int LINE_BYTES = 32,
    parameter int NUM_SETS   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rdata_valid,
    input  logic [BUS_W-1:0]  mem_rdata,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BUS_W-1:0]  mem_wr_data
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BEATS  = LINE_W / BUS_W;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int BOFF_W = $clog2(BUS_W / 8);
    localparam int WOFF_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFF_W - WOFF_W;
    localparam int WPB_W  = BOFF_W - WOFF_W;

    cc_state_e state_q, state_d;

    logic [ADDR_W-1:WOFF_W] addr_q;
    logic                   write_q;
    logic [WORD_W-1:0]      wdata_q;
    logic                   victim_q;
    logic [BEAT_W-1:0]      cnt_q;
    logic                   resp_valid_q;
    logic [WORD_W-1:0]      resp_data_q;
    logic [NUM_SETS-1:0]    lru_q;

    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] wsel;
    logic [BEAT_W-1:0] crit;
    logic [BEAT_W-1:0] fill_idx;
    logic [WPB_W-1:0]  wpb_sel;

    assign set_idx  = addr_q[OFF_W +: SET_W];
    assign req_tag  = addr_q[ADDR_W-1 -: TAG_W];
    assign wsel     = addr_q[OFF_W-1:WOFF_W];
    assign crit     = addr_q[OFF_W-1:BOFF_W];
    assign wpb_sel  = addr_q[BOFF_W-1:WOFF_W];
    assign fill_idx = crit + cnt_q;

    logic [TAG_W-1:0]    way_tag   [NUM_WAYS];
    logic [LINE_W-1:0]   way_line  [NUM_WAYS];
    logic [NUM_WAYS-1:0] way_valid;
    logic [NUM_WAYS-1:0] way_dirty;
    logic [NUM_WAYS-1:0] way_hit;
    logic [LINE_W-1:0]   fill_line;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        cache2w_way #(
            .NUM_SETS (NUM_SETS),
            .TAG_W    (TAG_W),
            .LINE_W   (LINE_W),
            .WORD_W   (WORD_W)
        ) u_way (
            .clk         (clk),
            .rst_n       (rst_n),
            .idx         (set_idx),
            .rd_tag      (way_tag[w]),
            .rd_valid    (way_valid[w]),
            .rd_dirty    (way_dirty[w]),
            .rd_line     (way_line[w]),
            .wr_line_en  (state_q == ST_INSTALL && victim_q == 1'(w)),
            .wr_tag      (req_tag),
            .wr_line     (fill_line),
            .wr_dirty    (write_q),
            .wr_word_en  (state_q == ST_LOOKUP && write_q && way_hit[w]),
            .wr_word_sel (wsel),
            .wr_word     (wdata_q)
        );
        assign way_hit[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    cache2w_fillbuf #(
        .BUS_W  (BUS_W),
        .BEATS  (BEATS),
        .WORD_W (WORD_W)
    ) u_fill (
        .clk        (clk),
        .beat_en    (state_q == ST_FETCH_DATA && mem_rdata_valid),
        .beat_idx   (fill_idx),
        .beat_data  (mem_rdata),
        .merge_en   (write_q && cnt_q == '0),
        .merge_sel  (wpb_sel),
        .merge_word (wdata_q),
        .line_out   (fill_line)
    );

    logic              hit_any;
    logic              hit_way;
    logic [LINE_W-1:0] hit_line;
    logic [WORD_W-1:0] hit_word;
    logic [WORD_W-1:0] crit_word;
    logic [LINE_W-1:0] vic_line;
    logic              pick_way;

    assign hit_any   = |way_hit;
    assign hit_way   = way_hit[1];
    assign hit_line  = way_line[hit_way];
    assign hit_word  = hit_line[wsel*WORD_W +: WORD_W];
    assign crit_word = mem_rdata[wpb_sel*WORD_W +: WORD_W];
    assign vic_line  = way_line[victim_q];

    // Victim choice: invalid ways first, then the way not used last.
    always_comb begin
        if (!way_valid[0])      pick_way = 1'b0;
        else if (!way_valid[1]) pick_way = 1'b1;
        else                    pick_way = ~lru_q[set_idx];
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit_any)                                    state_d = ST_IDLE;
                else if (way_valid[pick_way] && way_dirty[pick_way]) state_d = ST_EVICT;
                else                                            state_d = ST_FETCH_REQ;
            end
            ST_EVICT:      if (mem_wr_ready && cnt_q == BEAT_W'(BEATS-1)) state_d = ST_FETCH_REQ;
            ST_FETCH_REQ:  if (mem_rd_ready) state_d = ST_FETCH_DATA;
            ST_FETCH_DATA: if (mem_rdata_valid && cnt_q == BEAT_W'(BEATS-1)) state_d = ST_INSTALL;
            ST_INSTALL:    state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q       <= '0;
            write_q      <= 1'b0;
            wdata_q      <= '0;
            victim_q     <= 1'b0;
            cnt_q        <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
            lru_q        <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr[ADDR_W-1:WOFF_W];
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                    end
                end
                ST_LOOKUP: begin
                    cnt_q <= '0;
                    if (hit_any) begin
                        resp_valid_q   <= 1'b1;
                        resp_data_q    <= hit_word;
                        lru_q[set_idx] <= hit_way;
                    end else begin
                        victim_q <= pick_way;
                    end
                end
                ST_EVICT:     if (mem_wr_ready) cnt_q <= cnt_q + 1'b1;
                ST_FETCH_REQ: cnt_q <= '0;
                ST_FETCH_DATA: begin
                    if (mem_rdata_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == '0) begin
                            resp_valid_q <= 1'b1;
                            resp_data_q  <= crit_word;
                        end
                    end
                end
                ST_INSTALL:   lru_q[set_idx] <= victim_q;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        resp_valid   = resp_valid_q;
        resp_rdata   = resp_data_q;
        mem_wr_valid = (state_q == ST_EVICT);
        mem_wr_addr  = {way_tag[victim_q], set_idx, cnt_q, {BOFF_W{1'b0}}};
        mem_wr_data  = vic_line[cnt_q*BUS_W +: BUS_W];
        mem_rd_valid = (state_q == ST_FETCH_REQ);
        mem_rd_addr  = {req_tag, set_idx, crit, {BOFF_W{1'b0}}};
    end

    // R2: requests are word aligned.
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[WOFF_W-1:0] == '0);

    // R8: never more than one way matches.
    a_r8_one_way_hits: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOOKUP |-> $onehot0(way_hit));

    // R5: each response is a single-cycle strobe.
    a_r5_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R10: read request held stable until accepted.
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R10: write beat held stable until accepted.
    a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr)
                                          && $stable(mem_wr_data));
endmodule

// File: tb/cache2w_ctrl_tb.sv
module cache2w_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_rd_valid, mem_wr_valid;
    logic        mem_rd_ready = 1'b0, mem_wr_ready = 1'b0;
    logic [31:0] mem_rd_addr, mem_wr_addr;
    logic        mem_rdata_valid = 1'b0;
    logic [63:0] mem_rdata = '0, mem_wr_data;

    always #2 clk = ~clk;

    cache2w_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: written beats override a computed default.
    logic [63:0] wmem [logic [31:0]];
    logic [31:0] refw [logic [31:0]];

    function automatic logic [63:0] mem_beat(input logic [31:0] b);
        if (wmem.exists(b)) return wmem[b];
        return {b ^ 32'h5A5A_0000, b};
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [31:0] b;
        if (refw.exists(a)) return refw[a];
        b = {a[31:3], 3'b000};
        return a[2] ? (b ^ 32'h5A5A_0000) : b;
    endfunction

    bit          stall = 0, wr_tog = 0;
    int          rd_cnt = 0, wb_n = 0, rd_wbn_at = 0, beats_seen = 0;
    int          beat_left = 0, delay = 0, beat_k = 0, rd_wait = 0;
    logic [31:0] rd_last, wb_log [64];

    always @(posedge clk) if (mem_rdata_valid) beats_seen++;

    initial begin
        forever begin
            @(negedge clk);
            mem_wr_ready = stall ? wr_tog : 1'b1;
            wr_tog = ~wr_tog;
            if (mem_wr_valid && mem_wr_ready) begin
                wmem[mem_wr_addr] = mem_wr_data;
                wb_log[wb_n % 64] = mem_wr_addr;
                wb_n++;
            end
            mem_rdata_valid = 1'b0;
            if (beat_left > 0) begin
                if (delay > 0) delay--;
                else begin
                    mem_rdata_valid = 1'b1;
                    mem_rdata = mem_beat({rd_last[31:5], 2'(rd_last[4:3] + 2'(beat_k)), 3'b000});
                    beat_k++;
                    beat_left--;
                end
            end
            if (!mem_rd_valid) begin
                mem_rd_ready = 1'b0;
                rd_wait = stall ? 2 : 0;
            end else if (rd_wait > 0) begin
                mem_rd_ready = 1'b0;
                rd_wait--;
            end else if (!mem_rd_ready) begin
                mem_rd_ready = 1'b1;
                rd_last = mem_rd_addr;
                rd_cnt++;
                rd_wbn_at = wb_n;
                beat_left = 4;
                delay = 2;
                beat_k = 0;
            end
        end
    end

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                          input logic exp_miss, input logic exp_wb, input logic [31:0] wb_base);
        int rd0, wb0, bs0, k, guard;
        logic [31:0] got;
        logic rdy_at;
        int bs;
        @(negedge clk);
        guard = 0;
        while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
        rd0 = rd_cnt; wb0 = wb_n; bs0 = beats_seen;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        while (!resp_valid && k < 200) begin @(negedge clk); k++; end
        got = resp_rdata; rdy_at = req_ready; bs = beats_seen - bs0;
        guard = 0;
        while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
        if (!wr) check(got == exp_word(a), "R2 R3 R7 load data", got, exp_word(a));
        check((rd_cnt - rd0) == (exp_miss ? 1 : 0), "R8 R3 R6 read traffic", rd_cnt - rd0, exp_miss);
        check((wb_n - wb0) == (exp_wb ? 4 : 0), "R9 write-back beat count", wb_n - wb0, exp_wb ? 4 : 0);
        if (!exp_miss) check(k == 2, "R3 hit latency", k, 2);
        else begin
            check(rd_last == {a[31:3], 3'b000}, "R4 critical beat address", rd_last, {a[31:3], 3'b000});
            check(bs == 1 && rdy_at == 1'b0, "R5 early forward", {bs[15:0], 15'd0, rdy_at}, 32'h0001_0000);
            check(rd_wbn_at == wb_n, "R9 write-back before fill", rd_wbn_at, wb_n);
        end
        if (exp_wb)
            for (int j = 0; j < 4; j++)
                check(wb_log[(wb0 + j) % 64] == wb_base + 32'(8 * j), "R9 write-back beat order",
                      wb_log[(wb0 + j) % 64], wb_base + 32'(8 * j));
        if (wr) refw[a] = wd;
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        miss;
        logic        wb;
        logic [31:0] wb_base;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{1'b0, 32'h0000_20AC, 32'h0, 1'b1, 1'b0, 32'h0},
        '{1'b0, 32'h0000_20B8, 32'h0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0000_40BC, 32'h0, 1'b1, 1'b0, 32'h0},
        '{1'b1, 32'h0000_20A4, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0000_20A4, 32'h0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0000_40A0, 32'h0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0000_60B0, 32'h0, 1'b1, 1'b1, 32'h0000_20A0},
        '{1'b0, 32'h0000_40A8, 32'h0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0000_20A4, 32'h0, 1'b1, 1'b0, 32'h0},
        '{1'b1, 32'h0000_80B4, 32'h1234_5678, 1'b1, 1'b0, 32'h0},
        '{1'b0, 32'h0000_80B0, 32'h0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0000_80B4, 32'h0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0000_20C0, 32'h0, 1'b1, 1'b0, 32'h0},
        '{1'b0, 32'h0000_20A4, 32'h0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0000_A0A0, 32'h0, 1'b1, 1'b1, 32'h0000_80A0},
        '{1'b0, 32'h0000_80B4, 32'h0, 1'b1, 1'b0, 32'h0}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && resp_valid == 1'b0, "R1 idle after reset", {req_ready, resp_valid}, 2'b10);
        check(!mem_rd_valid && !mem_wr_valid, "R1 no memory traffic after reset", {mem_rd_valid, mem_wr_valid}, 0);

        // Table walk: R4 wrap fill, R6 store hit, R7 store miss, R8 victims, R9 write-back.
        for (int i = 0; i < 16; i++)
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].miss, VECS[i].wb, VECS[i].wb_base);

        // R10: back-pressure on both memory channels during a dirty eviction.
        stall = 1;
        access(1'b1, 32'h0000_80B4, 32'hCAFE_F00D, 1'b0, 1'b0, 32'h0);
        access(1'b0, 32'h0000_A0A0, 32'h0, 1'b0, 1'b0, 32'h0);
        access(1'b0, 32'h0000_C0A8, 32'h0, 1'b1, 1'b1, 32'h0000_80A0);
        access(1'b0, 32'h0000_80B4, 32'h0, 1'b1, 1'b0, 32'h0);
        stall = 0;

        // R1: reset mid-run invalidates every line.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && resp_valid == 1'b0, "R1 idle after second reset", {req_ready, resp_valid}, 2'b10);
        access(1'b0, 32'h0000_C0A8, 32'h0, 1'b1, 1'b0, 32'h0);
        access(1'b0, 32'h0000_80B4, 32'h0, 1'b1, 1'b0, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule